// File: doc/BRIEF.md
# Bulk command wrapper decoder

This block sits on the receive side of a bulk-only mass-storage endpoint. It takes the 31-byte command wrapper one byte per beat, pulls out the tag, the transfer length and the direction, and decides what kind of command the wrapper carries. It recognises one vendor command, a configuration-memory access, and checks it against fixed byte rules. It then reports a read or write request with its length. If the command breaks a rule, it reports a configuration error instead. Any other well-formed wrapper is handed on as a pass-through result.

Bytes arrive on a valid/ready stream with a last marker. One result per wrapper leaves on a second valid/ready channel. Back-pressure works like this: while a result is held and `res_ready` is low, `in_ready` is low and no input byte is taken. In the cycle that `res_ready` takes the held result, a new byte may be accepted. The opcode of the configuration command comes from a plain configuration input.

Top module: `cbw_cmd_decoder`

## Requirements
- R1: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `res_valid` rises in the cycle after the edge that took a byte flagged `in_last`. The result stays stable until it is taken with `res_ready`. `in_ready` is low exactly while a result is held and `res_ready` is low. A result can be taken and a byte accepted on the same edge.
- R2: Multi-byte fields are little-endian (lowest byte first). `res_tag` reports wrapper bytes 4..7. `res_len` reports bytes 8..11.
- R3: Bytes 0..3 must form 0x43425355, which arrives as 0x55, 0x53, 0x42, 0x43. Otherwise `res_kind` is 4 (signature error).
- R4: If the last marker comes with any byte count other than 31, `res_kind` is 5 (framing error) and `res_tag`, `res_len` and `res_dir` are 0. The next wrapper starts counting again from byte 0.
- R5: A wrapper is a configuration command when byte 15 (command byte 0) equals `cfg_opcode` and byte 16 (command byte 1) equals 0x26. Any other correctly framed, correctly signed wrapper gives `res_kind` 0 (pass-through), whatever its remaining bytes are.
- R6: `res_dir` is bit 7 of byte 12. A valid configuration command gives `res_kind` 1 (read) when that bit is 1, and `res_kind` 2 (write) when it is 0.
- R7: A configuration command needs byte 17 = 0x00, byte 18 = 0x02 and bytes 19..30 = 0x00. Any other value gives `res_kind` 3 (configuration error).
- R8: A configuration command with a length above 255 gives `res_kind` 3. A length of 0 to 255 is accepted.
- R9: When several faults occur together, the priority is framing error first, then signature error, then the pass-through/configuration decision, then the configuration rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_opcode | input | 8 | Opcode expected in command byte 0 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a wrapper |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 3 | 0 pass, 1 cfg read, 2 cfg write, 3 cfg error, 4 signature error, 5 framing error |
| res_dir | output | 1 | Direction bit (1 = device to host) |
| res_tag | output | 32 | Wrapper tag |
| res_len | output | 32 | Data transfer length |

## Verification
Two events can fall on the same edge: the consumer taking a held result, and the first byte of the next wrapper being accepted. The bench provokes this by holding `res_ready` low after one wrapper so that the next wrapper's first byte stalls. It then raises `res_ready` while that byte is waiting. Both results must then come out whole and in order, and `in_ready` must have been low during the stall. Sweeps over every command-byte position, every short and long wrapper length, and several opcodes are judged against kinds computed arithmetically from the bytes sent.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  typedef enum logic [2:0] {
    KIND_PASS      = 3'd0,
    KIND_CFG_READ  = 3'd1,
    KIND_CFG_WRITE = 3'd2,
    KIND_CFG_ERR   = 3'd3,
    KIND_SIG_ERR   = 3'd4,
    KIND_FRAME_ERR = 3'd5
  } cbw_kind_e;
endpackage

// File: rtl/cbw_byte_counter.sv
// Tracks the position of the current byte inside a wrapper; saturates on overlong input.
module cbw_byte_counter #(
  parameter int WRAP_BYTES = 31,
  parameter int CNT_W      = $clog2(WRAP_BYTES + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  output logic [CNT_W-1:0] pos,
  output logic             frame_ok
);
  localparam logic [CNT_W-1:0] SAT_POS  = CNT_W'(WRAP_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WRAP_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (beat) begin
      if (last)                 cnt_q <= '0;
      else if (cnt_q != SAT_POS) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pos      = cnt_q;
  assign frame_ok = beat && last && (cnt_q == LAST_POS);
endmodule

// File: rtl/cbw_field_capture.sv
// Stores the header bytes that precede the command block.
module cbw_field_capture #(
  parameter int HDR_BYTES = 15,
  parameter int CNT_W     = 6,
  parameter int TAG_POS   = 4,
  parameter int LEN_POS   = 8,
  parameter int FLG_POS   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [CNT_W-1:0] pos,
  input  logic [7:0]       data,
  output logic [31:0]      sig,
  output logic [31:0]      tag,
  output logic [31:0]      len,
  output logic [7:0]       flags
);
  logic [HDR_BYTES*8-1:0] hdr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
    end else if (beat) begin
      for (int b = 0; b < HDR_BYTES; b++) begin
        if (pos == CNT_W'(b)) hdr_q[b*8 +: 8] <= data;
      end
    end
  end

  // Little-endian: lower wrapper byte lands in the lower bits.
  assign sig   = hdr_q[31:0];
  assign tag   = hdr_q[TAG_POS*8 +: 32];
  assign len   = hdr_q[LEN_POS*8 +: 32];
  assign flags = hdr_q[FLG_POS*8 +: 8];
endmodule

// File: rtl/cbw_rule_check.sv
// Evaluates the command-block byte rules as bytes stream past, keeping sticky verdicts.
module cbw_rule_check #(
  parameter int         CB_OFFSET = 15,
  parameter int         CB_BYTES  = 16,
  parameter int         CNT_W     = 6,
  parameter int         OP_IDX    = 0,
  parameter int         MARK_IDX  = 1,
  parameter int         MEM_IDX   = 3,
  parameter logic [7:0] CFG_MARK  = 8'h26,
  parameter logic [7:0] MEM_SEL   = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [CNT_W-1:0] pos,
  input  logic [7:0]       data,
  input  logic [7:0]       opcode,
  output logic             not_cfg,
  output logic             rule_bad
);
  localparam logic [CNT_W-1:0] CB_LO  = CNT_W'(CB_OFFSET);
  localparam logic [CNT_W-1:0] CB_HI  = CNT_W'(CB_OFFSET + CB_BYTES);
  localparam logic [CNT_W-1:0] K_OP   = CNT_W'(OP_IDX);
  localparam logic [CNT_W-1:0] K_MARK = CNT_W'(MARK_IDX);
  localparam logic [CNT_W-1:0] K_MEM  = CNT_W'(MEM_IDX);

  logic             in_cb;
  logic [CNT_W-1:0] k;
  logic             cur_notcfg, cur_bad;
  logic             notcfg_q, bad_q;
  logic [7:0]       want;

  always_comb begin
    in_cb      = (pos >= CB_LO) && (pos < CB_HI);
    k          = pos - CB_LO;
    want       = (k == K_MEM) ? MEM_SEL : 8'h00;
    cur_notcfg = in_cb && (((k == K_OP) && (data != opcode)) ||
                           ((k == K_MARK) && (data != CFG_MARK)));
    cur_bad    = in_cb && (k != K_OP) && (k != K_MARK) && (data != want);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notcfg_q <= 1'b0;
      bad_q    <= 1'b0;
    end else if (beat) begin
      if (last) begin
        notcfg_q <= 1'b0;
        bad_q    <= 1'b0;
      end else begin
        notcfg_q <= notcfg_q | cur_notcfg;
        bad_q    <= bad_q | cur_bad;
      end
    end
  end

  assign not_cfg  = notcfg_q | (beat & cur_notcfg);
  assign rule_bad = bad_q | (beat & cur_bad);
endmodule

// File: rtl/cbw_cmd_decoder.sv
module cbw_cmd_decoder
  import cbw_pkg::*;
#(
  parameter int          WRAP_BYTES = 31,
  parameter int          CB_OFFSET  = 15,
  parameter int          CB_BYTES   = 16,
  parameter int          MAX_LEN    = 255,
  parameter logic [31:0] SIGNATURE  = 32'h43425355,
  parameter logic [7:0]  CFG_MARK   = 8'h26,
  parameter logic [7:0]  MEM_SEL    = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_opcode,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [2:0]  res_kind,
  output logic        res_dir,
  output logic [31:0] res_tag,
  output logic [31:0] res_len
);
  localparam int CNT_W = $clog2(WRAP_BYTES + 1) + 1;

  logic             beat, frame_ok, not_cfg, rule_bad;
  logic [CNT_W-1:0] pos;
  logic [31:0]      sig, tag, len;
  logic [7:0]       flags;
  cbw_kind_e        kind_d, kind_q;

  assign in_ready = !res_valid || res_ready;
  assign beat     = in_valid && in_ready;

  cbw_byte_counter #(.WRAP_BYTES(WRAP_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last),
    .pos(pos), .frame_ok(frame_ok)
  );

  cbw_field_capture #(.HDR_BYTES(CB_OFFSET), .CNT_W(CNT_W)) u_fields (
    .clk(clk), .rst_n(rst_n), .beat(beat), .pos(pos), .data(in_data),
    .sig(sig), .tag(tag), .len(len), .flags(flags)
  );

  cbw_rule_check #(
    .CB_OFFSET(CB_OFFSET), .CB_BYTES(CB_BYTES), .CNT_W(CNT_W),
    .CFG_MARK(CFG_MARK), .MEM_SEL(MEM_SEL)
  ) u_rules (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .pos(pos),
    .data(in_data), .opcode(cfg_opcode),
    .not_cfg(not_cfg), .rule_bad(rule_bad)
  );

  // Verdict priority: framing, signature, class, rules.
  always_comb begin
    if (!frame_ok)                              kind_d = KIND_FRAME_ERR;
    else if (sig != SIGNATURE)                  kind_d = KIND_SIG_ERR;
    else if (not_cfg)                           kind_d = KIND_PASS;
    else if (rule_bad || (len > 32'(MAX_LEN)))  kind_d = KIND_CFG_ERR;
    else if (flags[7])                          kind_d = KIND_CFG_READ;
    else                                        kind_d = KIND_CFG_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      kind_q    <= KIND_PASS;
      res_dir   <= 1'b0;
      res_tag   <= '0;
      res_len   <= '0;
    end else begin
      if (beat && in_last) begin
        res_valid <= 1'b1;
        kind_q    <= kind_d;
        res_dir   <= frame_ok ? flags[7] : 1'b0;
        res_tag   <= frame_ok ? tag : 32'h0;
        res_len   <= frame_ok ? len : 32'h0;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign res_kind = kind_q;
endmodule

// File: rtl/cbw_cmd_decoder_checker.sv
module cbw_cmd_decoder_checker #(
  parameter int MAX_LEN = 255
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_last,
  input logic        res_valid,
  input logic        res_ready,
  input logic [2:0]  res_kind,
  input logic        res_dir,
  input logic [31:0] res_tag,
  input logic [31:0] res_len
);
  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_kind) &&
      $stable(res_tag) && $stable(res_len) && $stable(res_dir));

  a_r1_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !in_ready);

  a_r1_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_ready && in_last));

  a_r8_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_kind == 3'd1 || res_kind == 3'd2) |-> res_len <= 32'(MAX_LEN));

  a_r6_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 3'd1 |-> res_dir);

  a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 3'd2 |-> !res_dir);

  a_r4_frame_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == 3'd5 |-> res_tag == 32'h0 && res_len == 32'h0 && !res_dir);
endmodule

bind cbw_cmd_decoder cbw_cmd_decoder_checker #(.MAX_LEN(MAX_LEN)) u_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .res_valid(res_valid), .res_ready(res_ready),
  .res_kind(res_kind), .res_dir(res_dir), .res_tag(res_tag), .res_len(res_len)
);

// File: tb/cbw_cmd_decoder_bench.sv
`timescale 1ns/1ps
module cbw_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_opcode = 8'hC5;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [2:0]  res_kind;
  logic        res_dir;
  logic [31:0] res_tag, res_len;

  always #5 clk = ~clk;

  cbw_cmd_decoder u_cbw_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_opcode(cfg_opcode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_dir(res_dir), .res_tag(res_tag), .res_len(res_len)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0]  fr [0:39];

  // Result log, filled on every handshake.
  int          rcount = 0;
  logic [2:0]  mk [0:511];
  logic [31:0] mt [0:511];
  logic [31:0] ml [0:511];
  logic        md [0:511];

  always @(posedge clk) begin
    if (rst_n && res_valid && res_ready && rcount < 512) begin
      mk[rcount] <= res_kind;
      mt[rcount] <= res_tag;
      ml[rcount] <= res_len;
      md[rcount] <= res_dir;
      rcount     <= rcount + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [31:0] tag, input logic [31:0] len, input logic rd);
    for (int i = 0; i < 40; i++) fr[i] = 8'h00;
    fr[0] = 8'h55; fr[1] = 8'h53; fr[2] = 8'h42; fr[3] = 8'h43;
    for (int i = 0; i < 4; i++) begin
      fr[4 + i] = tag[i*8 +: 8];
      fr[8 + i] = len[i*8 +: 8];
    end
    fr[12] = {rd, 7'h00};
    fr[14] = 8'h10;
    fr[15] = cfg_opcode;
    fr[16] = 8'h26;
    fr[18] = 8'h02;
  endtask

  function automatic logic [2:0] model_kind(input int n);
    logic [31:0] s, l;
    logic        bad;
    if (n != 31) return 3'd5;
    s = {fr[3], fr[2], fr[1], fr[0]};
    if (s != 32'h43425355) return 3'd4;
    if (fr[15] != cfg_opcode || fr[16] != 8'h26) return 3'd0;
    l   = {fr[11], fr[10], fr[9], fr[8]};
    bad = (fr[17] != 8'h00) || (fr[18] != 8'h02);
    for (int i = 19; i <= 30; i++) bad = bad || (fr[i] != 8'h00);
    if (bad || l > 32'd255) return 3'd3;
    return fr[12][7] ? 3'd1 : 3'd2;
  endfunction

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == n - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_res(input int target);
    while (rcount < target) @(negedge clk);
  endtask

  task automatic run(input int n, input string req);
    int          base;
    logic [2:0]  ek;
    logic [31:0] et, el;
    logic        ed;
    base = rcount;
    ek = model_kind(n);
    et = (n == 31) ? {fr[7], fr[6], fr[5], fr[4]} : 32'h0;
    el = (n == 31) ? {fr[11], fr[10], fr[9], fr[8]} : 32'h0;
    ed = (n == 31) ? fr[12][7] : 1'b0;
    send(n);
    wait_res(base + 1);
    chk(mk[base] == ek, req, 32'(mk[base]), 32'(ek));
    chk(mt[base] == et && ml[base] == el, "R2 tag/len", mt[base] ^ ml[base], et ^ el);
    chk(md[base] == ed, "R6 dir", 32'(md[base]), 32'(ed));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lens [0:3];
    logic [7:0]  ops [0:3];
    lens[0] = 32'd0; lens[1] = 32'd1; lens[2] = 32'd200; lens[3] = 32'd255;
    ops[0] = 8'h00; ops[1] = 8'h24; ops[2] = 8'hC5; ops[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 1'b0, "R1 reset res_valid", 32'(res_valid), 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 1);

    // R6 / R8: valid config commands, both directions, legal lengths
    for (int d = 0; d < 2; d++)
      for (int j = 0; j < 4; j++) begin
        build(32'h1000_0000 + 32'(j * 16 + d), lens[j], d[0]);
        run(31, "R6 R8 cfg ok");
      end

    // R8: lengths above the cap
    build(32'hCAFE0001, 32'd256, 1'b1);        run(31, "R8 len 256");
    build(32'hCAFE0002, 32'h0001_0000, 1'b0);  run(31, "R8 len 64K");
    build(32'hCAFE0003, 32'hFFFF_FFFF, 1'b1);  run(31, "R8 len max");

    // R7: every rule byte broken on its own
    for (int p = 17; p <= 30; p++) begin
      build(32'h7000_0000 + 32'(p), 32'd16, 1'b0);
      fr[p] = (p == 18) ? 8'h00 : 8'h01;
      run(31, "R7 rule byte low");
      build(32'h7100_0000 + 32'(p), 32'd16, 1'b1);
      fr[p] = (p == 18) ? 8'h03 : 8'h80;
      run(31, "R7 rule byte high");
    end

    // R5: opcode sweep
    for (int o = 0; o < 4; o++) begin
      cfg_opcode = ops[o];
      build(32'h5000_0000 + 32'(o), 32'd8, 1'b1);
      run(31, "R5 opcode match");
      fr[15] = ops[o] ^ 8'h01;
      run(31, "R5 opcode mismatch");
      build(32'h5100_0000 + 32'(o), 32'd999, 1'b0);
      fr[16] = 8'h27; fr[17] = 8'hAA; fr[30] = 8'h55;
      run(31, "R5 mark mismatch pass");
    end
    cfg_opcode = 8'hC5;

    // R3 / R9: signature faults on config and pass-through wrappers
    for (int b = 0; b < 4; b++) begin
      build(32'h3000_0000 + 32'(b), 32'd4, 1'b0);
      fr[b] = fr[b] ^ 8'h10;
      run(31, "R3 signature cfg");
      build(32'h3100_0000 + 32'(b), 32'd4, 1'b0);
      fr[16] = 8'h00;
      fr[b] = fr[b] ^ 8'h01;
      run(31, "R3 R9 signature over pass");
    end

    // R4 / R9: every wrong length, then recovery
    for (int n = 1; n <= 36; n++) begin
      if (n != 31) begin
        build(32'h4000_0000 + 32'(n), 32'd2, 1'b1);
        if (n % 2 == 0) fr[0] = 8'h00;
        run(n, "R4 R9 framing");
        build(32'h4100_0000 + 32'(n), 32'd3, 1'b1);
        run(31, "R4 recovery");
      end
    end

    // R1: result taken and next byte accepted on the same edge
    begin
      int          base;
      logic [2:0]  ka, kb;
      logic [31:0] ta, tb;
      base = rcount;
      res_ready = 1'b0;
      build(32'hAAAA_0001, 32'd100, 1'b1);
      ka = model_kind(31); ta = 32'hAAAA_0001;
      send(31);
      build(32'hBBBB_0002, 32'd50, 1'b0);
      kb = model_kind(31); tb = 32'hBBBB_0002;
      fork
        send(31);
        begin
          repeat (3) @(negedge clk);
          #2;
          chk(in_ready == 1'b0, "R1 stall in_ready", 32'(in_ready), 0);
          chk(res_valid == 1'b1 && res_kind == ka, "R1 held result",
              32'(res_kind), 32'(ka));
          @(negedge clk);
          res_ready = 1'b1;
        end
      join
      wait_res(base + 2);
      chk(mk[base] == ka && mt[base] == ta, "R1 first result", mt[base], ta);
      chk(mk[base+1] == kb && mt[base+1] == tb, "R1 second result", mt[base+1], tb);
      chk(rcount == base + 2, "R1 result count", 32'(rcount), 32'(base + 2));
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule